// File: doc/BRIEF.md
# E1 Transmit Line Encoder

This block sits between the terminal-side transmit data interface and the pulse shaper of a 2.048 Mbit/s line port. It takes the data rails and turns them into positive-mark and negative-mark indications, one symbol for each bit period. Everything runs in one fast system clock. The transmit bit clock and an independent reference clock come in as plain levels, and their edges are detected inside the block. Data is taken on each falling edge of the transmit bit clock.

The coding format has no configuration register. The block works it out from the negative-rail input. If that input keeps toggling, the two inputs are carried through as separate positive and negative rails. If it stays high for a long run, the positive input is encoded with HDB3. If it stays low for a long run, the positive input is encoded with AMI. A polarity input makes both rails active-low when the block is in dual-rail operation.

An alarm input replaces the coded stream with an alternating all-ones pattern, timed from the reference clock. The encoder keeps a fixed four-bit lookahead so that zero runs can be substituted. That delay applies in every mode, so the output timing is the same whichever format is active.

Top module: `e1_tx_line_encoder`

## Requirements
- R1: Data is sampled only on a falling edge of `tx_clk_in`. The mark outputs change only on such an edge or on a reference edge (R9). A sample appears on the outputs exactly four transmit edges after it was taken, in every mode. The first four transmit edges after reset produce no marks.
- R2: In dual-rail operation with `polarity_low` = 0, a sampled 1 on `tx_pos_in` gives `mark_pos` = 1, and a sampled 1 on `tx_neg_in` gives `mark_neg` = 1.
- R3: In dual-rail operation with `polarity_low` = 1, both data inputs are active-low. A sampled 0 gives the mark on that rail.
- R4: When the sampled `tx_neg_in` reaches 17 equal values in a row, the format changes. A run of 1s selects HDB3 and a run of 0s selects AMI. The new format applies from the next sample on.
- R5: A sampled `tx_neg_in` that differs from the previous sample selects dual-rail operation from the next sample on.
- R6: Reset clears both outputs to 0 and selects dual-rail operation. The previous-sample value of `tx_neg_in` is taken as 0. The first single-rail mark after reset is positive.
- R7: In AMI, each sampled 1 on `tx_pos_in` gives a mark whose polarity is opposite to the previous single-rail mark. Each 0 gives no mark on either rail.
- R8: In HDB3, every run of four zeros is replaced. It becomes B00V when the count of marks since the last violation is even, and 000V when that count is odd. B follows the alternation rule. V has the same polarity as the mark just before it.
- R9: While `all_ones_en` = 1, each rising edge of `ref_clk_in` outputs one mark on exactly one rail. The polarity alternates, and the first alarm mark after reset is positive. The data inputs and transmit edges do not change the outputs.
- R10: In single-rail operation, `polarity_low` has no effect on the coded output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than both line clocks |
| rst | input | 1 | Synchronous active-high reset |
| tx_clk_in | input | 1 | Transmit bit clock level; data is taken on its falling edge |
| ref_clk_in | input | 1 | Independent reference clock level; times the all-ones alarm |
| tx_pos_in | input | 1 | Positive-rail data, or single-rail data |
| tx_neg_in | input | 1 | Negative-rail data, or the format-select level |
| polarity_low | input | 1 | Active-low rail option for dual-rail operation |
| all_ones_en | input | 1 | Replaces the coded stream with the alternating all-ones alarm |
| mark_pos | output | 1 | Positive mark for the current symbol |
| mark_neg | output | 1 | Negative mark for the current symbol |

## Verification
The hardest cases to reach from the ports are the format changes in the middle of a stream. There, the four-symbol window spans two formats, or a zero run is already partly in the pipeline when HDB3 becomes active. The stimulus is one continuous stream. It moves from dual-rail, to a held-low select level, to AMI, to a held-high level, to HDB3 with zero runs of every length from zero to nine, and then back to a toggling select. Expected symbols come from a sequential scan of the recorded samples and the format each sample was taken under. An alarm burst in the middle of the run checks that the coded pipeline keeps running underneath it.

// File: rtl/e1tx_pkg.sv
package e1tx_pkg;

    typedef enum logic [1:0] {
        MODE_DUAL = 2'd0,
        MODE_AMI  = 2'd1,
        MODE_HDB3 = 2'd2
    } line_mode_e;

    // One sampled symbol travelling through the lookahead pipeline
    typedef struct packed {
        line_mode_e mode;
        logic       rail_p;
        logic       rail_n;
        logic       sub_b;
        logic       sub_v;
    } tx_sym_t;

    typedef struct packed {
        logic pos;
        logic neg;
    } mark_t;

    localparam int unsigned HDB3_RUN = 4;
    localparam tx_sym_t SYM_IDLE = '0;

    // A zero that may still take part in a substitution
    function automatic logic sym_is_free_zero(tx_sym_t s);
        return (s.mode == MODE_HDB3) && !s.rail_p && !s.sub_b && !s.sub_v;
    endfunction

endpackage

// File: rtl/e1tx_edge_tick.sv
module e1tx_edge_tick #(
    parameter bit FALLING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic tick
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig_in;
    end

    generate
        if (FALLING) begin : g_fall
            assign tick = sig_q & ~sig_in;
        end else begin : g_rise
            assign tick = ~sig_q & sig_in;
        end
    endgenerate
endmodule

// File: rtl/e1tx_mode_detect.sv
module e1tx_mode_detect
    import e1tx_pkg::*;
#(
    parameter int unsigned RUN_LIMIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       neg_raw,
    output line_mode_e mode
);
    localparam int unsigned CW = $clog2(RUN_LIMIT + 2);
    localparam logic [CW-1:0] SAT = CW'(RUN_LIMIT + 1);

    logic          prev_q;
    logic [CW-1:0] run_q, run_nx;
    line_mode_e    mode_nx;

    always_comb begin
        mode_nx = mode;
        if (neg_raw != prev_q) begin
            run_nx  = CW'(1);
            mode_nx = MODE_DUAL;
        end else begin
            run_nx = (run_q == SAT) ? SAT : run_q + CW'(1);
            if (run_nx == SAT) mode_nx = neg_raw ? MODE_HDB3 : MODE_AMI;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            run_q  <= '0;
            mode   <= MODE_DUAL;
        end else if (tick) begin
            prev_q <= neg_raw;
            run_q  <= run_nx;
            mode   <= mode_nx;
        end
    end
endmodule

// File: rtl/e1tx_sub_pipe.sv
module e1tx_sub_pipe
    import e1tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  tx_sym_t sym_in,
    input  logic    parity_even,
    output tx_sym_t sym_out
);
    localparam int unsigned DEPTH = HDB3_RUN;

    tx_sym_t stg  [DEPTH];
    tx_sym_t base [DEPTH];
    tx_sym_t win  [DEPTH];
    logic    all_free;

    always_comb begin
        base[0] = sym_in;
        for (int i = 1; i < DEPTH; i++) base[i] = stg[i-1];
        all_free = 1'b1;
        for (int i = 0; i < DEPTH; i++) all_free &= sym_is_free_zero(base[i]);
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) win[i] = base[i];
        if (all_free) begin
            win[0].sub_v = 1'b1;
            if (parity_even) win[DEPTH-1].sub_b = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= SYM_IDLE;
        end else if (tick) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= win[i];
        end
    end

    assign sym_out = stg[DEPTH-1];
endmodule

// File: rtl/e1tx_polarity.sv
module e1tx_polarity
    import e1tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  tx_sym_t cur,
    output mark_t   mark_nx,
    output logic    parity_even
);
    logic last_pos_q, last_nx;
    logic odd_q, odd_nx;
    logic mark_on, pol;

    always_comb begin
        mark_on = 1'b0;
        pol     = last_pos_q;
        last_nx = last_pos_q;
        odd_nx  = odd_q;
        mark_nx = '0;
        case (cur.mode)
            MODE_DUAL: begin
                mark_nx.pos = cur.rail_p;
                mark_nx.neg = cur.rail_n;
            end
            default: begin
                if (cur.sub_v) begin
                    mark_on = 1'b1;
                    pol     = last_pos_q;
                    odd_nx  = 1'b0;
                end else if (cur.rail_p || cur.sub_b) begin
                    mark_on = 1'b1;
                    pol     = ~last_pos_q;
                    last_nx = ~last_pos_q;
                    odd_nx  = ~odd_q;
                end
                mark_nx.pos = mark_on & pol;
                mark_nx.neg = mark_on & ~pol;
            end
        endcase
    end

    assign parity_even = ~odd_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_pos_q <= 1'b0;
            odd_q      <= 1'b0;
        end else if (tick) begin
            last_pos_q <= last_nx;
            odd_q      <= odd_nx;
        end
    end
endmodule

// File: rtl/e1tx_alarm.sv
module e1tx_alarm
    import e1tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  enable,
    output mark_t alarm_mark
);
    logic next_pos_q;

    always_ff @(posedge clk) begin
        if (rst)                 next_pos_q <= 1'b1;
        else if (tick && enable) next_pos_q <= ~next_pos_q;
    end

    assign alarm_mark.pos = next_pos_q;
    assign alarm_mark.neg = ~next_pos_q;
endmodule

// File: rtl/e1_tx_line_encoder.sv
module e1_tx_line_encoder
    import e1tx_pkg::*;
#(
    parameter int unsigned RUN_LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_clk_in,
    input  logic ref_clk_in,
    input  logic tx_pos_in,
    input  logic tx_neg_in,
    input  logic polarity_low,
    input  logic all_ones_en,
    output logic mark_pos,
    output logic mark_neg
);
    logic       tx_tick, ref_tick, parity_even;
    line_mode_e line_mode;
    tx_sym_t    sym_in, leave_sym;
    mark_t      coded, alarm_mark, out_q;

    e1tx_edge_tick #(.FALLING(1'b1)) u_tx_edge (
        .clk(clk), .rst(rst), .sig_in(tx_clk_in), .tick(tx_tick)
    );

    e1tx_edge_tick #(.FALLING(1'b0)) u_ref_edge (
        .clk(clk), .rst(rst), .sig_in(ref_clk_in), .tick(ref_tick)
    );

    e1tx_mode_detect #(.RUN_LIMIT(RUN_LIMIT)) u_mode (
        .clk(clk), .rst(rst), .tick(tx_tick), .neg_raw(tx_neg_in), .mode(line_mode)
    );

    always_comb begin
        sym_in      = SYM_IDLE;
        sym_in.mode = line_mode;
        if (line_mode == MODE_DUAL) begin
            sym_in.rail_p = tx_pos_in ^ polarity_low;
            sym_in.rail_n = tx_neg_in ^ polarity_low;
        end else begin
            sym_in.rail_p = tx_pos_in;
        end
    end

    e1tx_sub_pipe u_pipe (
        .clk(clk), .rst(rst), .tick(tx_tick), .sym_in(sym_in),
        .parity_even(parity_even), .sym_out(leave_sym)
    );

    e1tx_polarity u_pol (
        .clk(clk), .rst(rst), .tick(tx_tick), .cur(leave_sym),
        .mark_nx(coded), .parity_even(parity_even)
    );

    e1tx_alarm u_alarm (
        .clk(clk), .rst(rst), .tick(ref_tick), .enable(all_ones_en),
        .alarm_mark(alarm_mark)
    );

    always_ff @(posedge clk) begin
        if (rst)                           out_q <= '0;
        else if (all_ones_en && ref_tick)  out_q <= alarm_mark;
        else if (!all_ones_en && tx_tick)  out_q <= coded;
    end

    assign mark_pos = out_q.pos;
    assign mark_neg = out_q.neg;
endmodule

// File: rtl/e1tx_checker.sv
module e1tx_checker
    import e1tx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tx_tick,
    input logic       ref_tick,
    input logic       all_ones_en,
    input logic       tx_neg_in,
    input line_mode_e line_mode,
    input line_mode_e leaving_mode,
    input logic       mark_pos,
    input logic       mark_neg
);
    logic neg_q;

    always_ff @(posedge clk) begin
        if (rst)          neg_q <= 1'b0;
        else if (tx_tick) neg_q <= tx_neg_in;
    end

    // R1: outputs move only after a transmit or reference edge
    a_r1_change_on_tick: assert property (@(posedge clk) disable iff (rst)
        $changed({mark_pos, mark_neg}) |-> $past(tx_tick || ref_tick));

    // R9: each alarm symbol drives exactly one rail
    a_r9_alarm_one_rail: assert property (@(posedge clk) disable iff (rst)
        (all_ones_en && ref_tick) |=> (mark_pos ^ mark_neg));

    // R9: no change during alarm other than at a reference edge
    a_r9_alarm_hold: assert property (@(posedge clk) disable iff (rst)
        (all_ones_en && !ref_tick) |=> $stable({mark_pos, mark_neg}));

    // R5: a toggle of the select level returns to dual-rail
    a_r5_toggle_dual: assert property (@(posedge clk) disable iff (rst)
        (tx_tick && (tx_neg_in != neg_q)) |=> (line_mode == MODE_DUAL));

    // R4: a single-rail format agrees with the held select level
    a_r4_mode_level: assert property (@(posedge clk) disable iff (rst)
        (line_mode != MODE_DUAL) |-> (neg_q == (line_mode == MODE_HDB3)));

    // R8: a single-rail symbol never drives both rails
    a_r8_single_rail_excl: assert property (@(posedge clk) disable iff (rst)
        (!all_ones_en && tx_tick && leaving_mode != MODE_DUAL) |=> !(mark_pos && mark_neg));
endmodule

bind e1_tx_line_encoder e1tx_checker u_chk (
    .clk(clk), .rst(rst), .tx_tick(tx_tick), .ref_tick(ref_tick),
    .all_ones_en(all_ones_en), .tx_neg_in(tx_neg_in), .line_mode(line_mode),
    .leaving_mode(leave_sym.mode), .mark_pos(mark_pos), .mark_neg(mark_neg)
);

// File: tb/e1_tx_line_encoder_tb.sv
module e1_tx_line_encoder_tb;
    localparam int N       = 320;
    localparam int ALARM_T = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_clk_in = 1'b0, ref_clk_in = 1'b0;
    logic tx_pos_in = 1'b0, tx_neg_in = 1'b0;
    logic polarity_low = 1'b0, all_ones_en = 1'b0;
    logic mark_pos, mark_neg;

    int checks = 0;
    int errors = 0;

    logic  sp [N];
    logic  sn [N];
    logic  sv [N];
    int    md [N];
    logic  ep [N];
    logic  en [N];
    string tg [N];

    e1_tx_line_encoder u_dut (
        .clk(clk), .rst(rst), .tx_clk_in(tx_clk_in), .ref_clk_in(ref_clk_in),
        .tx_pos_in(tx_pos_in), .tx_neg_in(tx_neg_in), .polarity_low(polarity_low),
        .all_ones_en(all_ones_en), .mark_pos(mark_pos), .mark_neg(mark_neg)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic xp, input logic xn);
        checks++;
        if (mark_pos !== xp || mark_neg !== xn) begin
            errors++;
            $display("FAIL %s: actual p=%0b n=%0b expected p=%0b n=%0b", req, mark_pos, mark_neg, xp, xn);
        end
    endtask

    task automatic build();
        logic [15:0] lf = 16'hACE1;
        int nxt = 170;
        int j = 0;
        int prev = 0, run = 0, mode = 0;
        logic last = 1'b0, odd = 1'b0;
        int k = 0;
        for (int i = 0; i < N; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            sv[i] = 1'b0;
            if (i < 70 || i >= 290) begin
                sp[i] = lf[0]; sn[i] = lf[3];
                sv[i] = (i >= 40 && i < 70) || (i >= 305);
            end else if (i < 90) begin
                sp[i] = 1'b0; sn[i] = 1'b0;
            end else if (i < 150) begin
                sp[i] = lf[0]; sn[i] = 1'b0; sv[i] = (i >= 120);
            end else if (i < 170) begin
                sp[i] = 1'b0; sn[i] = 1'b1;
            end else if (i < 270) begin
                sn[i] = 1'b1; sv[i] = (i >= 220);
                if (i == nxt) begin
                    sp[i] = 1'b1; nxt = i + 1 + ((j * 7) % 10); j++;
                end else sp[i] = 1'b0;
            end else begin
                sp[i] = i[1]; sn[i] = i[0];
            end
        end
        // format each sample is taken under (R4, R5)
        for (int i = 0; i < N; i++) begin
            md[i] = mode;
            if (int'(sn[i]) != prev) begin
                run = 1; mode = 0; prev = int'(sn[i]);
            end else begin
                if (run < 17) run++;
                if (run == 17) mode = sn[i] ? 2 : 1;
            end
        end
        // sequential line coding (R2, R3, R7, R8, R10)
        while (k < N) begin
            ep[k] = 1'b0; en[k] = 1'b0;
            if (md[k] == 0) begin
                ep[k] = sp[k] ^ sv[k]; en[k] = sn[k] ^ sv[k];
                tg[k] = (k >= 270 && k < 290) ? "R5" : (sv[k] ? "R3" : "R2");
                k++;
            end else if (md[k] == 2 && k + 3 < N && md[k+1] == 2 && md[k+2] == 2 && md[k+3] == 2
                         && !sp[k] && !sp[k+1] && !sp[k+2] && !sp[k+3]) begin
                for (int q = 0; q < 4; q++) begin
                    ep[k+q] = 1'b0; en[k+q] = 1'b0;
                    tg[k+q] = sv[k+q] ? "R10" : "R8";
                end
                if (!odd) begin
                    last = ~last; ep[k] = last; en[k] = ~last;
                end
                ep[k+3] = last; en[k+3] = ~last;
                odd = 1'b0;
                k += 4;
            end else begin
                if (sp[k]) begin
                    last = ~last; ep[k] = last; en[k] = ~last; odd = ~odd;
                end
                if (k < 170 && k >= 70) tg[k] = "R4";
                else tg[k] = sv[k] ? "R10" : (md[k] == 2 ? "R8" : "R7");
                k++;
            end
        end
    endtask

    task automatic tx_bit(input logic p, input logic n, input logic inv);
        @(negedge clk);
        tx_pos_in = p; tx_neg_in = n; polarity_low = inv; tx_clk_in = 1'b1;
        @(negedge clk);
        @(negedge clk) tx_clk_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic ref_pulse();
        @(negedge clk) ref_clk_in = 1'b1;
        @(negedge clk) ref_clk_in = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic ap = 1'b1;
        build();
        repeat (3) @(negedge clk);
        chk("R6", 1'b0, 1'b0);
        rst = 1'b0;
        for (int t = 0; t < N; t++) begin
            if (t == ALARM_T) begin
                @(negedge clk) all_ones_en = 1'b1;
                for (int i = 0; i < 4; i++) begin
                    ref_pulse();
                    chk("R9", ap, ~ap);
                    ap = ~ap;
                end
                tx_bit(sp[t], sn[t], sv[t]);
                chk("R9", ~ap, ap);   // data edge leaves alarm symbol in place
                ref_pulse();
                chk("R9", ap, ~ap);
                ap = ~ap;
                @(negedge clk) all_ones_en = 1'b0;
            end else begin
                tx_bit(sp[t], sn[t], sv[t]);
                if (t < 4) chk("R1", 1'b0, 1'b0);
                else       chk(tg[t-4], ep[t-4], en[t-4]);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule